// File: doc/BRIEF.md
# Timestamp Counter with Auxiliary PWM Mode

The block is a free-running up-counter that normally serves as a timestamp. Setting a mode bit turns it into a single-output pulse-width modulator. In that mode the counter runs from zero up to a programmed terminal value and then returns to zero. The output is high from the start of each cycle until the counter reaches a compare value.

The terminal value and the compare value are each written into a shadow register. Both shadows move into the active pair only when the counter wraps, so a running waveform never sees a half-updated setting. The programmed terminal value is the wanted period minus one. Writes that would make no sense are dropped: a terminal value of zero, or a compare value beyond the period. Software restarts a cycle by writing zero into the counter.

A single write port carries all configuration. It has an enable, a two-bit register select and a data word as wide as the counter.

Top module: `aux_pwm_timer`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears its state. Afterwards `cnt_out` is 0, `pwm_out` is 0, the block is stopped in timestamp mode, both terminal registers (shadow and active) hold `DEF_PRD`, and both compare registers hold 0.
- R2: A write with `wr_sel` = 0 loads the control word. Bit 0 selects PWM mode (1) or timestamp mode (0). Bit 1 is the run bit. While run is 1 the counter advances by one per clock; while run is 0 it holds its value.
- R3: In timestamp mode the counter wraps from all ones to zero and `pwm_out` stays 0.
- R4: In PWM mode with run set, a clock edge that finds the counter at or above the active terminal value sets it to 0. A terminal value P therefore gives a cycle of P+1 clocks.
- R5: In PWM mode `pwm_out` is 1 exactly while the counter is below the active compare value. A compare value of 0 keeps the output low for the whole cycle. A compare value of P+1 keeps it high for the whole cycle.
- R6: The shadow terminal and compare values are copied into the active registers only on a wrap edge (R4). Shadow writes in mid-cycle leave the current cycle unchanged.
- R7: A write with `wr_sel` = 2 sets the shadow terminal value unless the data is 0, in which case it is dropped. A write with `wr_sel` = 3 sets the shadow compare value only if the data is at most the shadow terminal value plus one; otherwise it is dropped.
- R8: Writes with `wr_sel` = 2 or 3 are dropped while the block is in timestamp mode.
- R9: A write with `wr_sel` = 1 loads the counter with the data at that edge, in any mode and whether running or not. Writing 0 restarts the cycle. This write takes precedence over counting, and at that edge it also suppresses the wrap and the shadow copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 2 | Register select: 0 control, 1 counter, 2 terminal shadow, 3 compare shadow |
| wr_data | input | CNT_W | Write data |
| cnt_out | output | CNT_W | Current counter value |
| pwm_out | output | 1 | PWM output |

## Verification
Every write lands on the rising edge that samples it, so its effect on `cnt_out` and `pwm_out` is visible one edge after the write is driven. The output depends on the counter and the active compare value through logic alone, so it follows the counter with no further delay. A shadow write reaches the output only at the first wrap edge after it, which can be many cycles later. The bench tracks this with a cycle-stepped arithmetic model that updates at each rising edge from the values present before that edge. It compares both outputs at the following falling edge, so every result is sampled in the cycle it is due. The bench sweeps all terminal values from 0 to 6 against compare values up to two above the terminal value, including the ones that must be rejected.

// File: rtl/aux_pwm_pkg.sv
package aux_pwm_pkg;

    localparam int unsigned MAX_W = 32;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_COUNT   = 2'd1,
        SEL_PERIOD  = 2'd2,
        SEL_COMPARE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic run;
        logic pwm_mode;
    } ctrl_t;

    // compare may reach one past the terminal value (full-high cycle)
    function automatic logic cmp_in_range(input logic [MAX_W:0] cmp,
                                          input logic [MAX_W:0] prd);
        return cmp <= prd + 1'b1;
    endfunction

endpackage

// File: rtl/aux_pwm_cfg.sv
module aux_pwm_cfg
    import aux_pwm_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned DEF_PRD = 999
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] sh_prd,
    output logic [CNT_W-1:0] sh_cmp
);

    localparam logic [CNT_W-1:0] RST_PRD = CNT_W'(DEF_PRD);

    logic ctrl_we, prd_we, cmp_we;

    always_comb begin
        ctrl_we = wr_en && (wr_sel == SEL_CTRL);
        prd_we  = wr_en && (wr_sel == SEL_PERIOD) && ctrl.pwm_mode
                  && (wr_data != '0);
        cmp_we  = wr_en && (wr_sel == SEL_COMPARE) && ctrl.pwm_mode
                  && cmp_in_range((MAX_W+1)'(wr_data), (MAX_W+1)'(sh_prd));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            sh_prd <= RST_PRD;
            sh_cmp <= '0;
        end else begin
            if (ctrl_we) begin
                ctrl.pwm_mode <= wr_data[0];
                ctrl.run      <= wr_data[1];
            end
            if (prd_we) sh_prd <= wr_data;
            if (cmp_we) sh_cmp <= wr_data;
        end
    end

    // R7: a zero terminal value never reaches the shadow
    p_prd_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        sh_prd != '0);

    // R7: a newly accepted compare value is within range of the shadow period
    p_cmp_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (sh_cmp != $past(sh_cmp)) |->
            ({1'b0, sh_cmp} <= {1'b0, sh_prd} + 1'b1));

    // R8: shadows are frozen while in timestamp mode
    p_capture_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        !ctrl.pwm_mode |=> ($stable(sh_prd) && $stable(sh_cmp)));

endmodule

// File: rtl/aux_pwm_count.sv
module aux_pwm_count
    import aux_pwm_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned DEF_PRD = 999
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] sh_prd,
    input  logic [CNT_W-1:0] sh_cmp,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] act_prd,
    output logic [CNT_W-1:0] act_cmp
);

    localparam logic [CNT_W-1:0] RST_PRD = CNT_W'(DEF_PRD);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic cnt_we, wrap;

    always_comb begin
        cnt_we = wr_en && (wr_sel == SEL_COUNT);
        wrap   = ctrl.run && ctrl.pwm_mode && !cnt_we && (cnt >= act_prd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            act_prd <= RST_PRD;
            act_cmp <= '0;
        end else if (cnt_we) begin
            cnt <= wr_data;
        end else if (wrap) begin
            cnt     <= '0;
            act_prd <= sh_prd;
            act_cmp <= sh_cmp;
        end else if (ctrl.run) begin
            cnt <= cnt + ONE;
        end
    end

    // R2: stopped counter holds
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !cnt_we) |=> $stable(cnt));

    // R2/R3: running counter steps by one when not wrapping
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && !cnt_we && !(ctrl.pwm_mode && cnt >= act_prd))
            |=> (cnt == $past(cnt) + ONE));

    // R4: reaching the terminal value returns the counter to zero
    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && ctrl.pwm_mode && !cnt_we && cnt >= act_prd)
            |=> (cnt == '0));

    // R6: active settings change only on a wrap edge
    p_active_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.run && ctrl.pwm_mode && !cnt_we && cnt >= act_prd)
            |=> ($stable(act_prd) && $stable(act_cmp)));

    // R9: direct counter write lands on the next edge
    p_load_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> (cnt == $past(wr_data)));

endmodule

// File: rtl/aux_pwm_timer.sv
module aux_pwm_timer
    import aux_pwm_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned DEF_PRD = 999
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_out,
    output logic             pwm_out
);

    reg_sel_e         sel;
    ctrl_t            ctrl;
    logic [CNT_W-1:0] sh_prd, sh_cmp, act_prd, act_cmp, cnt;

    assign sel = reg_sel_e'(wr_sel);

    aux_pwm_cfg #(.CNT_W(CNT_W), .DEF_PRD(DEF_PRD)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (sel),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .sh_prd  (sh_prd),
        .sh_cmp  (sh_cmp)
    );

    aux_pwm_count #(.CNT_W(CNT_W), .DEF_PRD(DEF_PRD)) u_count (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (sel),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .sh_prd  (sh_prd),
        .sh_cmp  (sh_cmp),
        .cnt     (cnt),
        .act_prd (act_prd),
        .act_cmp (act_cmp)
    );

    // R5: high from cycle start until the compare match
    always_comb begin
        cnt_out = cnt;
        pwm_out = ctrl.pwm_mode && (cnt < act_cmp);
    end

    // R5: first count of a cycle drives high whenever compare is nonzero
    p_start_high_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.pwm_mode && cnt == '0 && act_cmp != '0) |-> pwm_out);

endmodule

// File: tb/aux_pwm_timer_tb.sv
`timescale 1ns/1ps
module aux_pwm_timer_tb;

    localparam int W   = 8;
    localparam int DEF = 9;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [1:0]   wr_sel;
    logic [W-1:0] wr_data;
    logic [W-1:0] cnt_out;
    logic         pwm_out;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    logic         m_mode, m_run;
    logic [W-1:0] m_cnt, m_sprd, m_scmp, m_aprd, m_acmp;

    always #4 clk = ~clk;

    aux_pwm_timer #(.CNT_W(W), .DEF_PRD(DEF)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cnt_out(cnt_out), .pwm_out(pwm_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at a falling edge, advance one rising edge, compare at next falling edge
    task automatic step(input logic we, input logic [1:0] sel,
                        input logic [W-1:0] d, input string tag);
        logic         n_mode, n_run;
        logic [W-1:0] n_cnt, n_sprd, n_scmp, n_aprd, n_acmp;
        logic         wrap_e;
        wr_en = we; wr_sel = sel; wr_data = d;
        n_mode = m_mode; n_run = m_run; n_cnt = m_cnt;
        n_sprd = m_sprd; n_scmp = m_scmp; n_aprd = m_aprd; n_acmp = m_acmp;
        if (we && sel == 2'd0) begin n_mode = d[0]; n_run = d[1]; end
        if (we && sel == 2'd2 && m_mode && d != 0) n_sprd = d;
        if (we && sel == 2'd3 && m_mode && (int'(d) <= int'(m_sprd) + 1)) n_scmp = d;
        wrap_e = m_run && m_mode && !(we && sel == 2'd1) && (m_cnt >= m_aprd);
        if (we && sel == 2'd1) n_cnt = d;
        else if (wrap_e) begin n_cnt = '0; n_aprd = m_sprd; n_acmp = m_scmp; end
        else if (m_run) n_cnt = m_cnt + 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        m_mode = n_mode; m_run = n_run; m_cnt = n_cnt;
        m_sprd = n_sprd; m_scmp = n_scmp; m_aprd = n_aprd; m_acmp = n_acmp;
        check({tag, " cnt_out"}, int'(cnt_out), int'(m_cnt));
        check({tag, " pwm_out"}, int'(pwm_out), int'(m_mode && (m_cnt < m_acmp)));
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        m_mode = 0; m_run = 0; m_cnt = 0;
        m_sprd = W'(DEF); m_scmp = 0; m_aprd = W'(DEF); m_acmp = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 cnt_out", int'(cnt_out), 0);
        check("R1 pwm_out", int'(pwm_out), 0);
        rst = 1'b0;
        idle(4, "R1 stopped");

        // R8: writes to period/compare ignored in timestamp mode
        step(1'b1, 2'd2, 8'd3, "R8 prd write");
        step(1'b1, 2'd3, 8'd2, "R8 cmp write");

        // R3: timestamp mode runs through wraparound, output low
        step(1'b1, 2'd0, 8'b10, "R2 run");
        step(1'b1, 2'd1, 8'd250, "R9 load");
        idle(12, "R3 wrap");

        // R2: stop holds, R9: load while stopped
        step(1'b1, 2'd0, 8'b00, "R2 stop");
        idle(3, "R2 hold");
        step(1'b1, 2'd1, 8'd5, "R9 load stopped");
        idle(3, "R9 hold");

        // R4/R5/R8: PWM mode uses reset terminal value (R8 writes did not land)
        step(1'b1, 2'd0, 8'b11, "R2 pwm run");
        step(1'b1, 2'd1, 8'd0, "R9 restart");
        idle(25, "R4 default period");

        // R5/R7: near-exhaustive sweep of terminal and compare values
        for (int p = 0; p <= 6; p++) begin
            for (int c = 0; c <= p + 2; c++) begin
                step(1'b1, 2'd2, W'(p), "R7 prd");
                step(1'b1, 2'd3, W'(c), "R7 cmp");
                step(1'b1, 2'd1, 8'd0, "R9 restart");
                idle(20, "R5 sweep");
            end
        end

        // R6: mid-cycle shadow writes wait for the wrap
        step(1'b1, 2'd2, 8'd9, "R6 prd");
        step(1'b1, 2'd3, 8'd6, "R6 cmp");
        idle(22, "R6 settle");
        step(1'b1, 2'd3, 8'd2, "R6 cmp mid");
        step(1'b1, 2'd2, 8'd4, "R6 prd mid");
        idle(20, "R6 after");

        // R4: counter loaded above terminal value wraps on next edge
        step(1'b1, 2'd1, 8'd200, "R9 load high");
        idle(4, "R4 above prd");

        // R7: compare of terminal+1 gives full-high, zero gives full-low
        step(1'b1, 2'd3, 8'd5, "R7 full high");
        idle(12, "R5 full high");
        step(1'b1, 2'd3, 8'd6, "R7 reject");
        step(1'b1, 2'd3, 8'd0, "R7 zero");
        idle(12, "R5 zero low");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule